// File: doc/BRIEF.md
# Two-Channel PIO Access Controller

This block sits behind a byte receiver and runs one access session at a time on a pair of open-drain output channels. Each session opens with two control bytes. The first chooses which channels take part, how data bits are directed, whether two-channel writes land together or one at a time, and whether the activity latches are wiped. The second byte only completes the header; its content is not used. Once both bytes are in, the block returns one status byte. After that, each bit slot from the master either drives one channel or samples one channel's sense input.

Each channel has an output flip-flop that controls its pull-down transistor, a sense input that reports the real pin level for closed-loop checking, and an activity latch. The latch records any change of the sensed level until a session header asks for it to be cleared. Byte framing and line timing are handled outside this block.

Top module: `pio_access_ctrl`

## Requirements
- R1: After reset both pull-downs are released (`pio_drive` = 00), `info_valid` and `slot_rvalid` are low, and both activity latches are clear.
- R2: A session starts with `sess_start`. The first `rx_valid` byte is control byte 1 and the second is control byte 2, whose value is ignored. `info_valid` pulses in the cycle after control byte 2 is accepted, with `info_byte` = {2'b00, activity[B:A], sense[B:A], drive[B:A]} sampled in the accept cycle. Any later byte in the same session is ignored.
- R3: Control byte 1 bits [1:0] select the channels: 01 selects channel A only, 10 selects channel B only, 11 selects both, alternating A, B, A, … starting with A, and 00 makes every slot do nothing.
- R4: In a write slot, `slot_wbit`=1 releases the selected pull-down (`pio_drive` bit = 0) and `slot_wbit`=0 turns it on (bit = 1), visible the cycle after the slot. Without a write slot, the output flip-flops keep their value.
- R5: In a read slot, `slot_rvalid` pulses the cycle after the slot, and `slot_rbit` carries the selected channel's `pio_sense` level as sampled at the slot.
- R6: Control byte 1 bit 4 sets the first direction (1 = write, 0 = read). With bit 3 (toggle) at 0, every slot uses that direction. With bit 3 at 1, the direction flips after every TOG_BITS slots.
- R7: With both channels selected, bit 2 = 0 makes each pin update in the cycle after its own slot. With bit 2 = 1, the value written in an A slot is held back, and both pins update together in the cycle after the following B slot.
- R8: A change of a channel's `pio_sense` sets that channel's activity latch. The latch stays set across sessions until it is cleared.
- R9: Control byte 1 bit 5 = 1 clears both activity latches when that byte is accepted, so the info byte of the same session reports them as 0.
- R10: Bit slots seen before the info byte of the current session, and all slots when the selection is 00, change no output and produce no `slot_rvalid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sess_start | input | 1 | Starts a new session header |
| rx_valid | input | 1 | Received control byte strobe |
| rx_byte | input | 8 | Received control byte |
| info_valid | output | 1 | Status byte strobe |
| info_byte | output | 8 | Status byte |
| slot_valid | input | 1 | Data bit slot strobe |
| slot_wbit | input | 1 | Bit value for a write slot |
| slot_rvalid | output | 1 | Read result strobe |
| slot_rbit | output | 1 | Read result bit |
| pio_sense | input | 2 | Sensed pin levels, bit 0 = A |
| pio_drive | output | 2 | Pull-down enables, bit 0 = A, 1 = transistor on |

## Verification
The hardest case to reach is synchronous two-channel writing that crosses toggle-group boundaries. An A value has to be held back while slots alternate between channels, and the direction has to flip at the right slot count. Sessions with random headers and random slot counts of up to several toggle groups reach this state often. A bench model tracks the pending A value, the alternation pointer and the group parity. Separate sense flips, made between slots and between sessions, drive the activity latches. Clear and no-clear headers are mixed so that both sticky and cleared states are reported in the info byte.

// File: rtl/pio_acc_pkg.sv
package pio_acc_pkg;

   typedef enum logic [1:0] {
      PH_CTRL1 = 2'd0,
      PH_CTRL2 = 2'd1,
      PH_DATA  = 2'd2
   } phase_t;

   typedef struct packed {
      logic       clr_act;
      logic       wr_first;
      logic       tog;
      logic       sync;
      logic [1:0] sel;
   } ctrl_t;

   localparam int CTRL_SEL_LSB = 0;
   localparam int CTRL_SYNC    = 2;
   localparam int CTRL_TOG     = 3;
   localparam int CTRL_WRFIRST = 4;
   localparam int CTRL_CLR     = 5;

endpackage

// File: rtl/pio_acc_cmd.sv
module pio_acc_cmd
   import pio_acc_pkg::*;
#(
   parameter int BYTE_W = 8,
   parameter int NCH    = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sess_start,
   input  logic              rx_valid,
   input  logic [BYTE_W-1:0] rx_byte,
   input  logic [NCH-1:0]    drive,
   input  logic [NCH-1:0]    sense,
   input  logic [NCH-1:0]    act,
   output ctrl_t             ctrl,
   output phase_t            phase,
   output logic              clr,
   output logic              data_start,
   output logic              info_valid,
   output logic [BYTE_W-1:0] info_byte
);

   localparam int INFO_USED = 3 * NCH;

   if (BYTE_W < INFO_USED || BYTE_W < 6) begin : g_bad_width
      $error("pio_acc_cmd: BYTE_W too small for control and status fields");
   end

   phase_t            phase_q;
   ctrl_t             ctrl_q;
   logic              info_valid_q;
   logic [BYTE_W-1:0] info_q;
   logic              take1, take2;
   logic              unused_hi;

   assign take1 = rx_valid && !sess_start && (phase_q == PH_CTRL1);
   assign take2 = rx_valid && !sess_start && (phase_q == PH_CTRL2);
   assign clr        = take1 && rx_byte[CTRL_CLR];
   assign data_start = take2;
   assign unused_hi  = ^rx_byte[BYTE_W-1:6];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q      <= PH_CTRL1;
         ctrl_q       <= '0;
         info_valid_q <= 1'b0;
         info_q       <= '0;
      end else begin
         info_valid_q <= 1'b0;
         if (sess_start) begin
            phase_q <= PH_CTRL1;
         end else if (take1) begin
            ctrl_q.sel      <= rx_byte[CTRL_SEL_LSB +: 2];
            ctrl_q.sync     <= rx_byte[CTRL_SYNC];
            ctrl_q.tog      <= rx_byte[CTRL_TOG];
            ctrl_q.wr_first <= rx_byte[CTRL_WRFIRST];
            ctrl_q.clr_act  <= rx_byte[CTRL_CLR];
            phase_q         <= PH_CTRL2;
         end else if (take2) begin
            phase_q      <= PH_DATA;
            info_valid_q <= 1'b1;
            info_q       <= BYTE_W'({act, sense, drive});
         end
      end
   end

   assign ctrl       = ctrl_q;
   assign phase      = phase_q;
   assign info_valid = info_valid_q;
   assign info_byte  = info_q;

   AST_INFO_AFTER_CTRL2: assert property (@(posedge clk) disable iff (!rst_n)
      info_valid_q |-> $past(rx_valid && !sess_start && phase_q == PH_CTRL2)); // R2

   AST_INFO_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      info_valid_q |=> !info_valid_q); // R2

endmodule

// File: rtl/pio_acc_chan.sv
module pio_acc_chan (
   input  logic clk,
   input  logic rst_n,
   input  logic wr_en,
   input  logic wr_val,
   input  logic clr,
   input  logic sense,
   output logic drive,
   output logic act
);

   logic drive_q, act_q, prev_q, primed_q, evt;

   assign evt = primed_q && (sense != prev_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         drive_q  <= 1'b0;
         act_q    <= 1'b0;
         prev_q   <= 1'b0;
         primed_q <= 1'b0;
      end else begin
         prev_q   <= sense;
         primed_q <= 1'b1;
         if (wr_en) drive_q <= wr_val;
         if (clr)      act_q <= 1'b0;
         else if (evt) act_q <= 1'b1;
      end
   end

   assign drive = drive_q;
   assign act   = act_q;

   AST_DRIVE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> $stable(drive_q)); // R4

   AST_ACT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (act_q && !clr) |=> act_q); // R8

   AST_ACT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> !act_q); // R9

endmodule

// File: rtl/pio_acc_seq.sv
module pio_acc_seq
   import pio_acc_pkg::*;
#(
   parameter int NCH      = 2,
   parameter int TOG_BITS = 8
) (
   input  logic           clk,
   input  logic           rst_n,
   input  ctrl_t          ctrl,
   input  phase_t         phase,
   input  logic           data_start,
   input  logic           slot_valid,
   input  logic           slot_wbit,
   input  logic [NCH-1:0] sense,
   output logic [NCH-1:0] wr_en,
   output logic [NCH-1:0] wr_val,
   output logic           rvalid,
   output logic           rbit
);

   localparam int CW = (TOG_BITS > 2) ? $clog2(TOG_BITS) : 1;
   localparam logic [CW-1:0] CNT_LAST = CW'(TOG_BITS - 1);

   if (NCH != 2) begin : g_bad_nch
      $error("pio_acc_seq: exactly two channels supported");
   end
   if (TOG_BITS < 2 || (TOG_BITS % 2) != 0) begin : g_bad_tog
      $error("pio_acc_seq: TOG_BITS must be even and at least 2");
   end

   logic          ptr_q, par_q, pend_q, rvalid_q, rbit_q;
   logic [CW-1:0] cnt_q;
   logic          active, both, ch, is_wr, sync2;

   always_comb begin
      active = (phase == PH_DATA) && slot_valid && (ctrl.sel != 2'b00);
      both   = (ctrl.sel == 2'b11);
      sync2  = both && ctrl.sync;
      ch     = both ? ptr_q : (ctrl.sel == 2'b10);
      is_wr  = ctrl.tog ? (ctrl.wr_first ^ par_q) : ctrl.wr_first;
      wr_en  = '0;
      wr_val = '0;
      if (active && is_wr) begin
         if (sync2) begin
            if (ch) begin
               wr_en  = 2'b11;
               wr_val = {~slot_wbit, pend_q};
            end
         end else begin
            wr_en[ch]  = 1'b1;
            wr_val[ch] = ~slot_wbit;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ptr_q    <= 1'b0;
         par_q    <= 1'b0;
         pend_q   <= 1'b0;
         cnt_q    <= '0;
         rvalid_q <= 1'b0;
         rbit_q   <= 1'b0;
      end else begin
         rvalid_q <= active && !is_wr;
         if (active && !is_wr) rbit_q <= sense[ch];
         if (data_start) begin
            ptr_q  <= 1'b0;
            par_q  <= 1'b0;
            pend_q <= 1'b0;
            cnt_q  <= '0;
         end else if (active) begin
            if (both) ptr_q <= ~ptr_q;
            if (cnt_q == CNT_LAST) begin
               cnt_q <= '0;
               par_q <= ~par_q;
            end else begin
               cnt_q <= cnt_q + 1'b1;
            end
            if (is_wr && sync2 && !ch) pend_q <= ~slot_wbit;
         end
      end
   end

   assign rvalid = rvalid_q;
   assign rbit   = rbit_q;

   AST_SYNC_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
      sync2 |-> (wr_en == 2'b00 || wr_en == 2'b11)); // R7

   AST_ONE_CHANNEL: assert property (@(posedge clk) disable iff (!rst_n)
      !sync2 |-> ($countones(wr_en) <= 1)); // R3

   AST_RVALID_FROM_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
      rvalid_q |-> $past(slot_valid && phase == PH_DATA)); // R10

endmodule

// File: rtl/pio_access_ctrl.sv
module pio_access_ctrl
   import pio_acc_pkg::*;
#(
   parameter int BYTE_W   = 8,
   parameter int TOG_BITS = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sess_start,
   input  logic              rx_valid,
   input  logic [BYTE_W-1:0] rx_byte,
   output logic              info_valid,
   output logic [BYTE_W-1:0] info_byte,
   input  logic              slot_valid,
   input  logic              slot_wbit,
   output logic              slot_rvalid,
   output logic              slot_rbit,
   input  logic [1:0]        pio_sense,
   output logic [1:0]        pio_drive
);

   localparam int NCH = 2;

   ctrl_t          ctrl;
   phase_t         phase;
   logic           clr, data_start;
   logic [NCH-1:0] wr_en, wr_val, drive, act;

   pio_acc_cmd #(.BYTE_W(BYTE_W), .NCH(NCH)) u_cmd (
      .clk(clk), .rst_n(rst_n), .sess_start(sess_start),
      .rx_valid(rx_valid), .rx_byte(rx_byte),
      .drive(drive), .sense(pio_sense), .act(act),
      .ctrl(ctrl), .phase(phase), .clr(clr), .data_start(data_start),
      .info_valid(info_valid), .info_byte(info_byte)
   );

   pio_acc_seq #(.NCH(NCH), .TOG_BITS(TOG_BITS)) u_seq (
      .clk(clk), .rst_n(rst_n), .ctrl(ctrl), .phase(phase),
      .data_start(data_start), .slot_valid(slot_valid), .slot_wbit(slot_wbit),
      .sense(pio_sense), .wr_en(wr_en), .wr_val(wr_val),
      .rvalid(slot_rvalid), .rbit(slot_rbit)
   );

   for (genvar i = 0; i < NCH; i++) begin : g_ch
      pio_acc_chan u_chan (
         .clk(clk), .rst_n(rst_n), .wr_en(wr_en[i]), .wr_val(wr_val[i]),
         .clr(clr), .sense(pio_sense[i]), .drive(drive[i]), .act(act[i])
      );
   end

   assign pio_drive = drive;

   AST_RESET_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (pio_drive == 2'b00)); // R1

endmodule

// File: tb/pio_access_ctrl_bench.sv
module pio_access_ctrl_bench;
   localparam int TOG_BITS = 8;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic sess_start = 1'b0, rx_valid = 1'b0, slot_valid = 1'b0, slot_wbit = 1'b0;
   logic [7:0] rx_byte = 8'h00;
   logic [1:0] pio_sense = 2'b00;
   logic info_valid, slot_rvalid, slot_rbit;
   logic [7:0] info_byte;
   logic [1:0] pio_drive;

   int checks = 0, fails = 0;

   // model state
   logic [1:0] m_drive = 2'b00, m_act = 2'b00;
   logic [7:0] m_ctrl = 8'h00;
   logic m_data = 1'b0, m_ptr = 1'b0, m_par = 1'b0, m_pend = 1'b0;
   int m_cnt = 0;

   always #4 clk = ~clk;

   pio_access_ctrl #(.BYTE_W(8), .TOG_BITS(TOG_BITS)) u_pio_access_ctrl (
      .clk(clk), .rst_n(rst_n), .sess_start(sess_start), .rx_valid(rx_valid),
      .rx_byte(rx_byte), .info_valid(info_valid), .info_byte(info_byte),
      .slot_valid(slot_valid), .slot_wbit(slot_wbit), .slot_rvalid(slot_rvalid),
      .slot_rbit(slot_rbit), .pio_sense(pio_sense), .pio_drive(pio_drive)
   );

   task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      @(negedge clk);
   endtask

   function automatic logic [7:0] info_exp();
      return {2'b00, m_act, pio_sense, m_drive};
   endfunction

   task automatic open_session(input logic [7:0] c1, input logic [7:0] c2);
      sess_start = 1'b1; tick(); sess_start = 1'b0;
      m_data = 1'b0;
      rx_valid = 1'b1; rx_byte = c1; tick();
      m_ctrl = c1;
      if (c1[5]) m_act = 2'b00;
      chk("R2 no info after first byte", {7'd0, info_valid}, 8'h00);
      rx_byte = c2; tick(); rx_valid = 1'b0;
      m_data = 1'b1; m_ptr = 1'b0; m_par = 1'b0; m_pend = 1'b0; m_cnt = 0;
      chk("R2 info_valid after second byte", {7'd0, info_valid}, 8'h01);
      chk(c1[5] ? "R9 info byte after clear" : "R2 R8 info byte", info_byte, info_exp());
   endtask

   task automatic slot(input logic w);
      logic both, ch, wr, ev, eb;
      ev = 1'b0; eb = 1'b0;
      if (m_data && m_ctrl[1:0] != 2'b00) begin
         both = (m_ctrl[1:0] == 2'b11);
         ch   = both ? m_ptr : (m_ctrl[1:0] == 2'b10);
         wr   = m_ctrl[3] ? (m_ctrl[4] ^ m_par) : m_ctrl[4];
         if (wr) begin
            if (both && m_ctrl[2]) begin
               if (!ch) m_pend = ~w;
               else m_drive = {~w, m_pend};
            end else begin
               m_drive[ch] = ~w;
            end
         end else begin
            ev = 1'b1; eb = pio_sense[ch];
         end
         if (both) m_ptr = ~m_ptr;
         m_cnt++;
         if (m_cnt == TOG_BITS) begin m_cnt = 0; m_par = ~m_par; end
      end
      slot_valid = 1'b1; slot_wbit = w; tick(); slot_valid = 1'b0;
      chk("R4 R7 R10 drive after slot", {6'd0, pio_drive}, {6'd0, m_drive});
      chk("R5 R6 R10 read strobe", {7'd0, slot_rvalid}, {7'd0, ev});
      if (ev) chk("R5 read bit", {7'd0, slot_rbit}, {7'd0, eb});
   endtask

   task automatic flip(input logic [1:0] m);
      pio_sense = pio_sense ^ m; tick();
      m_act = m_act | m;
      chk("R8 drive unaffected by sense", {6'd0, pio_drive}, {6'd0, m_drive});
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      fails++;
      $display("FAIL R10 watchdog actual=timeout expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      int unsigned seed;
      seed = 32'd17;
      void'($urandom(seed));
      repeat (3) tick();
      chk("R1 reset drive", {6'd0, pio_drive}, 8'h00);
      chk("R1 reset info_valid", {7'd0, info_valid}, 8'h00);
      chk("R1 reset rvalid", {7'd0, slot_rvalid}, 8'h00);
      rst_n = 1'b1; tick();
      chk("R1 drive after release", {6'd0, pio_drive}, 8'h00);

      // R1 activity clear: session without clear bit
      open_session(8'h11, 8'hFF);
      // R4 single channel A writes
      slot(1'b0); slot(1'b1); slot(1'b0);
      // R10 byte in data phase ignored
      rx_valid = 1'b1; rx_byte = 8'h22; tick(); rx_valid = 1'b0;
      chk("R2 late byte ignored", {7'd0, info_valid}, 8'h00);
      slot(1'b0);
      // R3 channel B, then reads
      open_session(8'h12, 8'h00); slot(1'b0); slot(1'b1); slot(1'b0);
      open_session(8'h02, 8'h00); pio_sense = 2'b10; tick(); m_act = 2'b10;
      slot(1'b0); slot(1'b1);
      // R10 slots before info ignored
      sess_start = 1'b1; tick(); sess_start = 1'b0; m_data = 1'b0;
      rx_valid = 1'b1; rx_byte = 8'h13; tick(); rx_valid = 1'b0; m_ctrl = 8'h13;
      slot(1'b1); slot(1'b1);
      // R3 selection 00 does nothing
      open_session(8'h10, 8'h00); slot(1'b1); slot(1'b1);
      // R7 interleaved
      open_session(8'h13, 8'h00); slot(1'b0); slot(1'b0); slot(1'b1); slot(1'b1);
      // R7 synchronous
      open_session(8'h17, 8'h00); slot(1'b0);
      chk("R7 sync A held", {6'd0, pio_drive}, 8'h00);
      slot(1'b0); slot(1'b1); slot(1'b1);
      // R6 toggle across groups
      open_session(8'h1F, 8'h00);
      for (int i = 0; i < 3 * TOG_BITS; i++) slot(i[0]);
      open_session(8'h0B, 8'h00);
      for (int i = 0; i < 2 * TOG_BITS; i++) slot(1'b0);
      // R8 sticky, R9 clear
      flip(2'b01); flip(2'b11);
      open_session(8'h00, 8'h00);
      open_session(8'h00, 8'h00);
      open_session(8'h20, 8'h00);

      // random sessions
      for (int s = 0; s < 60; s++) begin
         logic [7:0] c1;
         int n;
         c1 = 8'($urandom());
         open_session(c1, 8'($urandom()));
         n = $urandom_range(0, 3 * TOG_BITS);
         for (int k = 0; k < n; k++) begin
            if ($urandom_range(0, 5) == 0) flip(2'($urandom_range(1, 3)));
            slot(1'($urandom()));
         end
      end

      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule